// File: doc/BRIEF.md
# One-Bit FIR Decimation Filter

This block is the digital back end of an oversampling delta-sigma converter. It receives a single-bit modulator stream together with a per-bit valid qualifier. Each accepted bit enters a delay line, and every tap of that line either adds or subtracts its own low-pass coefficient. No multipliers are needed. The signed sum is formed once per accepted bit, but only one result per oversampling period reaches the output, where it is marked by a one-cycle strobe.

The coefficients come from a window function that is evaluated at elaboration, so a change to the tap count rebuilds the table with no edits. The weights are much finer than a simple count of ones in a period, so the decimated word has many more levels than the oversampling ratio alone would give. The output register holds each sample until the next strobe.

Top module: `onebit_fir_decim`

## Requirements
- R1: While reset is asserted and after reset is released, `sample_valid` is 0 and `sample_out` is 0 until the first strobe.
- R2: Bit value 1 stands for the positive reference and adds its coefficient. Bit value 0 stands for the negative reference and subtracts it. The coefficient for the newest bit (tap 0) up to the oldest (tap TAPS-1) is c(k) = (k+1)·(TAPS−k). A strobed sample equals the sum over k of ±c(k), taken over the last TAPS accepted bits including the one that triggered it.
- R3: After reset, a strobe occurs in the cycle that follows acceptance of every OSR-th bit (the OSR-th, the 2·OSR-th, and so on). It lasts exactly one cycle, and no strobe occurs at any other time.
- R4: A cycle with `bit_valid` low shifts no bit, does not advance the decimation phase, and produces no strobe.
- R5: No strobe is issued until at least TAPS bits have been accepted since reset. A decimation point that falls earlier is skipped.
- R6: For an even tap count, a stream of alternating ones and zeros (mid-scale input) yields an output of exactly 0.
- R7: A stream of all ones yields +Σc(k), and a stream of all zeros yields −Σc(k). The output width holds ±Σc(k) without overflow.
- R8: `sample_out` holds its value in every cycle in which `sample_valid` is low.
- R9: A stream of five ones per eight bits (one quarter of positive full scale) gives positive samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_in | input | 1 | Modulator bit, 1 = positive reference |
| bit_valid | input | 1 | Accept `bit_in` in this cycle |
| sample_out | output | SW | Signed decimated sample, SW = clog2(Σc+1)+1 |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bench builds the block with OSR = 8 and TAPS = 12. With these values the first decimation point arrives before the window has filled, so the skip rule is exercised. They also give many strobes in a short run and a table small enough to compute by hand (Σc = 364). Because 12 is even, the mid-scale stream must cancel exactly. An 8-bit repeating pattern slides across a 12-tap window at different phases, so successive samples differ and every coefficient position is tested. A behavioural first-order modulator drives the quarter-scale and zero levels through the same path.

// File: rtl/onebit_fir_pkg.sv
package onebit_fir_pkg;

  // Parabolic window weight for tap k of a taps-long line.
  function automatic int unsigned tap_coef(input int unsigned k, input int unsigned taps);
    return (k + 1) * (taps - k);
  endfunction

  function automatic int unsigned coef_total(input int unsigned taps);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < taps; k++) acc += tap_coef(k, taps);
    return acc;
  endfunction

  // Signed width that holds +/- the coefficient total.
  function automatic int unsigned sum_width(input int unsigned taps);
    return $clog2(coef_total(taps) + 1) + 1;
  endfunction

endpackage

// File: rtl/onebit_fir_delay.sv
module onebit_fir_delay #(
  parameter int unsigned TAPS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            bit_in,
  output logic [TAPS-1:0] hist_q,
  output logic [TAPS-1:0] hist_nx
);

  always_comb begin
    hist_nx = hist_q;
    if (shift_en) hist_nx = {hist_q[TAPS-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_nx;
  end

  // R4: an idle cycle leaves the line untouched
  a_r4_line_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q));

  // R2: the accepted bit lands in tap 0
  a_r2_newest_tap: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist_q[0] == $past(bit_in));

endmodule

// File: rtl/onebit_fir_taps.sv
module onebit_fir_taps #(
  parameter int unsigned TAPS = 32,
  parameter int unsigned SW   = onebit_fir_pkg::sum_width(TAPS)
) (
  input  logic [TAPS-1:0]       hist,
  output logic signed [SW-1:0]  sum
);

  logic signed [SW-1:0] term [TAPS];

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam logic signed [SW-1:0] CK = SW'(onebit_fir_pkg::tap_coef(k, TAPS));
    assign term[k] = hist[k] ? CK : -CK;
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < TAPS; k++) sum = sum + term[k];
  end

endmodule

// File: rtl/onebit_fir_phase.sv
module onebit_fir_phase #(
  parameter int unsigned OSR  = 128,
  parameter int unsigned TAPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic fire
);

  localparam int unsigned PW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int unsigned FW = $clog2(TAPS + 1);
  localparam logic [PW-1:0] LAST = PW'(OSR - 1);
  localparam logic [FW-1:0] FULL = FW'(TAPS);

  logic [PW-1:0] phase_q, phase_nx;
  logic [FW-1:0] fill_q, fill_nx;

  always_comb begin
    phase_nx = phase_q;
    fill_nx  = fill_q;
    if (in_valid) begin
      phase_nx = (phase_q == LAST) ? '0 : phase_q + 1'b1;
      if (fill_q != FULL) fill_nx = fill_q + 1'b1;
    end
  end

  assign fire = in_valid && (phase_q == LAST) && (fill_q >= FW'(TAPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      fill_q  <= '0;
    end else begin
      phase_q <= phase_nx;
      fill_q  <= fill_nx;
    end
  end

  // R3: phase wraps after the last slot of a period
  a_r3_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && phase_q == LAST) |=> phase_q == '0);

  // R4: counters stall without input
  a_r4_phase_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(phase_q) && $stable(fill_q)));

  // R5: fill count never passes the tap count
  a_r5_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FULL);

endmodule

// File: rtl/onebit_fir_decim.sv
module onebit_fir_decim #(
  parameter int unsigned OSR  = 128,
  parameter int unsigned TAPS = 32,
  localparam int unsigned SW  = onebit_fir_pkg::sum_width(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_in,
  input  logic                 bit_valid,
  output logic signed [SW-1:0] sample_out,
  output logic                 sample_valid
);

  localparam logic signed [SW-1:0] TOT = SW'(onebit_fir_pkg::coef_total(TAPS));

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [TAPS-1:0]      hist_q, hist_nx;
  logic signed [SW-1:0] sum;
  logic                 fire;
  logic signed [SW-1:0] sample_q, sample_nx;
  logic                 valid_q, valid_nx;

  onebit_fir_delay #(.TAPS(TAPS)) u_delay (
    .clk(clk), .rst_n(rst_int_n), .shift_en(bit_valid), .bit_in(bit_in),
    .hist_q(hist_q), .hist_nx(hist_nx)
  );

  // The sum is taken over the line including the bit accepted this cycle.
  onebit_fir_taps #(.TAPS(TAPS), .SW(SW)) u_taps (
    .hist(hist_nx), .sum(sum)
  );

  onebit_fir_phase #(.OSR(OSR), .TAPS(TAPS)) u_phase (
    .clk(clk), .rst_n(rst_int_n), .in_valid(bit_valid), .fire(fire)
  );

  always_comb begin
    sample_nx = sample_q;
    valid_nx  = 1'b0;
    if (fire) begin
      sample_nx = sum;
      valid_nx  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      sample_q <= sample_nx;
      valid_q  <= valid_nx;
    end
  end

  assign sample_out   = sample_q;
  assign sample_valid = valid_q;

  // R3: strobe is a single-cycle pulse (OSR >= 2)
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    sample_valid |=> !sample_valid);

  // R4: every strobe follows an accepted bit
  a_r4_needs_input: assert property (@(posedge clk) disable iff (!rst_int_n)
    sample_valid |-> $past(bit_valid));

  // R7: no overflow beyond the coefficient total
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_int_n)
    sample_valid |-> (sample_out <= TOT && sample_out >= -TOT));

  // R8: output holds between strobes
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !sample_valid |-> $stable(sample_out));

  // R2: a sum of +/- terms keeps the parity of the total
  a_r2_parity: assert property (@(posedge clk) disable iff (!rst_int_n)
    sample_valid |-> sample_out[0] == TOT[0]);

endmodule

// File: tb/onebit_fir_decim_test.sv
`timescale 1ns/1ps
module onebit_fir_decim_test;

  localparam int OSR  = 8;
  localparam int TAPS = 12;
  localparam int SW   = onebit_fir_pkg::sum_width(TAPS);

  function automatic int bench_total();
    int s;
    s = 0;
    for (int k = 0; k < TAPS; k++) s += (k + 1) * (TAPS - k);
    return s;
  endfunction
  localparam int TOTAL = bench_total();
  localparam int NOREF = 32'h7fff_ffff;

  // Stimulus table: repeating 8-bit pattern and final expected sample.
  localparam logic [7:0] PAT   [6] = '{8'hFF, 8'h00, 8'hAA, 8'h55, 8'hB5, 8'h3C};
  localparam int         FINAL [6] = '{TOTAL, -TOTAL, 0, 0, NOREF, NOREF};

  logic clk, rst_n, bit_in, bit_valid;
  logic signed [SW-1:0] sample_out;
  logic sample_valid;

  onebit_fir_decim #(.OSR(OSR), .TAPS(TAPS)) uut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
    .sample_out(sample_out), .sample_valid(sample_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string cur_req = "R2";
  logic [TAPS-1:0] m_hist;
  int m_cnt;
  bit exp_flag;
  int exp_val;

  function automatic int ref_dot(input logic [TAPS-1:0] h);
    int s;
    s = 0;
    for (int k = 0; k < TAPS; k++) s += h[k] ? (k + 1) * (TAPS - k) : -((k + 1) * (TAPS - k));
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic b);
    @(negedge clk);
    bit_in = b;
    bit_valid = 1'b1;
    @(posedge clk);
    m_hist = {m_hist[TAPS-2:0], b};
    m_cnt++;
    if ((m_cnt % OSR) == 0 && m_cnt >= TAPS) begin
      exp_flag = 1'b1;
      exp_val  = ref_dot(m_hist);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_valid = 1'b0;
      @(posedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bit_valid = 1'b0;
    bit_in = 1'b0;
    m_hist = '0;
    m_cnt = 0;
    exp_flag = 1'b0;
    repeat (2) @(negedge clk);
    chk(sample_valid === 1'b0, "R1", sample_valid, 0);
    chk(sample_out === '0, "R1", sample_out, 0);
    rst_n = 1'b1;
    idle(4);
  endtask

  // First-order behavioural modulator: level in -4..4 against a reference of 4.
  task automatic modulate(input int level, input int nbits);
    int acc;
    acc = 0;
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = (acc >= 0);
      acc += level - (b ? 4 : -4);
      push(b);
    end
  endtask

  // Strobe monitor against the bench reference dot product (R2, R3).
  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_flag) begin
        chk(sample_valid === 1'b1, cur_req, sample_valid, 1);
        chk(sample_out == exp_val, cur_req, sample_out, exp_val);
        exp_flag = 1'b0;
      end else if (sample_valid) begin
        chk(1'b0, cur_req, 1, 0);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    bit_in = 1'b0;
    bit_valid = 1'b0;
    do_reset();
    #1 chk(sample_valid === 1'b0 && sample_out === '0, "R1", sample_out, 0);

    // Table walk: R2 general, R6 mid-scale, R7 full scale.
    for (int e = 0; e < 6; e++) begin
      cur_req = (FINAL[e] == 0) ? "R6" : ((FINAL[e] == NOREF) ? "R2" : "R7");
      for (int i = 0; i < 4 * OSR; i++) push(PAT[e][7 - (i % 8)]);
      idle(1);
      #1;
      if (FINAL[e] != NOREF) chk(sample_out == FINAL[e], cur_req, sample_out, FINAL[e]);
      else chk(sample_out == ref_dot(m_hist), "R2", sample_out, ref_dot(m_hist));
    end

    // R5: fill gating after a reset, and R8 hold while filling.
    cur_req = "R5";
    do_reset();
    for (int i = 0; i < OSR; i++) push(i[0]);
    #1 chk(sample_valid === 1'b0, "R5", sample_valid, 0);
    for (int i = 0; i < OSR - 1; i++) push(1'b1);
    #1 chk(sample_out == 0, "R8", sample_out, 0);
    push(1'b0);
    #1 chk(sample_valid === 1'b1, "R5", sample_valid, 1);

    // R8: value holds through idle cycles and a partial period.
    begin
      int held;
      idle(1);
      #1 held = sample_out;
      idle(3);
      for (int i = 0; i < OSR - 1; i++) push(i[1]);
      #1 chk(sample_out == held, "R8", sample_out, held);
      push(1'b1);
      idle(1);
    end

    // R4: gaps between accepted bits change nothing but timing.
    cur_req = "R4";
    for (int i = 0; i < 3 * OSR; i++) begin
      push(PAT[4][7 - (i % 8)]);
      idle(1 + (i % 3));
    end
    idle(2 * OSR);
    #1 chk(sample_valid === 1'b0, "R4", sample_valid, 0);

    // R9: quarter-scale modulator stream, then zero level (R6).
    cur_req = "R9";
    modulate(1, 6 * OSR);
    idle(1);
    #1 chk(sample_out > 0, "R9", sample_out, 1);
    cur_req = "R6";
    modulate(0, 4 * OSR);
    idle(1);
    #1 chk(sample_out == 0, "R6", sample_out, 0);
    cur_req = "R2";
    modulate(-2, 4 * OSR);
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R3: watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule